// File: doc/BRIEF.md
# Flag Offset Register Load Sequencer

This block holds the two programmable flag thresholds of one FIFO: the empty offset n, used by the almost-empty comparison, and the full offset m, used by the almost-full comparison. Each offset is split into a low byte register and a high register that carries the remaining offset bits. The high register's width follows the FIFO depth. There is no address bus. Accesses walk through the four registers in a fixed rotating order. Writes take their data from the FIFO data input on the write clock. Reads return the register contents on the read clock, for the FIFO output path to present.

A dual-role pin sets the role of the block. Its level is captured while reset is asserted. High gives a second write enable for depth expansion, and the offsets keep their defaults. Low gives a load strobe. While the strobe is low, write-clock accesses go to the offset registers and read-clock accesses come from them, instead of going to the FIFO array. The block also decodes the plain FIFO write and read requests that the surrounding FIFO gates with its full and empty state. The combined n and m values are exported for the flag comparators.

Top module: `flagoff_seq`

## Requirements
- R1: The `ld_i` level is sampled on every clock edge while `rst_ni` is low, and on the first edge after release. If it was high (wide mode), no offset register is ever written or read: `n_o` and `m_o` keep their values, `rdata_vld_o` stays 0, and `fifo_re_o` is the plain read decode.
- R2: In load mode, a write-clock edge with `ld_i`=0, `wen1_ni`=0 and no read request stores `wdata_i` into the register under the write pointer. The order is 0 empty-low, 1 empty-high, 2 full-low, 3 full-high, and the fifth access wraps back to 0.
- R3: Reset sets n = m = 7, clears both access pointers to register 0, and clears `err_o`, `rdata_vld_o` and `rdata_o`.
- R4: Both pointers persist across load sessions. After `ld_i` returns high and later falls again, the next access continues at the following register.
- R5: `fifo_we_o` is 1 exactly when `wen1_ni`=0 and `ld_i`=1. With `ld_i`=0 and `wen1_ni`=1 no register changes.
- R6: In load mode, a read-clock edge with `ld_i`=0, `ren1_ni`=`ren2_ni`=0 and `wen1_ni`=1 loads the register under the read pointer, zero-extended, into `rdata_o` and raises `rdata_vld_o` for one cycle. It then advances the read pointer in the same order as R2.
- R7: A low register stores `wdata_i[7:0]`. A high register stores `wdata_i[OFF_W-9:0]`, and all other input bits are dropped. n = {empty-high, empty-low} and m = {full-high, full-low}.
- R8: In load mode with `ld_i`=0, `wen1_ni`=0 and both read enables low, the edge writes nothing and reads nothing, and both pointers hold. `err_o` is 1 for the following write-clock cycle.
- R9: `fifo_re_o` is 1 when both read enables are low, except in load mode while `ld_i`=0.
- R10: A value written at an edge appears on `n_o`/`m_o` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Dual-role pin: second write enable or offset load strobe |
| wen1_ni | input | 1 | Write enable 1, active low |
| ren1_ni | input | 1 | Read enable 1, active low |
| ren2_ni | input | 1 | Read enable 2, active low |
| wdata_i | input | DATA_W | FIFO data input |
| fifo_we_o | output | 1 | FIFO array write request |
| fifo_re_o | output | 1 | FIFO array read request |
| rdata_o | output | DATA_W | Offset read-back value |
| rdata_vld_o | output | 1 | Read-back value updated on the last read edge |
| err_o | output | 1 | Simultaneous offset write and read was refused |
| n_o | output | OFF_W | Empty offset n |
| m_o | output | OFF_W | Full offset m |

## Verification
The bench builds the block with DEPTH=2048, so each offset is 11 bits and each high register is 3 bits wide. With this depth, all-ones input data shows the dropped high bits, and a 9-bit read-back shows the zero extension. A single clock feeds both ports, so the refused simultaneous access happens on one shared edge. The bench sweeps all sixteen combinations of the load pin and the three enables in both modes, and runs enough accesses to wrap both pointers several times against its own model.

// File: rtl/flagoff_pkg.sv
package flagoff_pkg;
  localparam int unsigned LO_W = 8;
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } off_sel_e;
endpackage

// File: rtl/flagoff_mode.sv
module flagoff_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  output logic prog_o
);
  logic run_q;
  logic prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  // pin level tracked until the first edge after reset release
  always_ff @(posedge clk_i) begin
    if (!run_q) prog_q <= ~ld_i;
  end

  assign prog_o = prog_q;
endmodule

// File: rtl/flagoff_ptr.sv
module flagoff_ptr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  output logic [1:0] ptr_o
);
  logic [1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= 2'd0;
    else if (adv_i) ptr_q <= ptr_q + 2'd1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/flagoff_regs.sv
module flagoff_regs
  import flagoff_pkg::*;
#(
  parameter int unsigned OFF_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       wsel_i,
  input  logic [LO_W-1:0]  wdata_i,
  input  logic [1:0]       rsel_i,
  output logic [OFF_W-1:0] n_o,
  output logic [OFF_W-1:0] m_o,
  output logic [LO_W-1:0]  rd_val_o
);
  localparam int unsigned HI_W = (OFF_W > LO_W) ? OFF_W - LO_W : 1;
  localparam logic [LO_W-1:0] DEF_LO = LO_W'(7);

  logic [LO_W-1:0] e_lo_q, f_lo_q;
  logic [LO_W-1:0] e_hi_ext, f_hi_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_lo_q <= DEF_LO;
      f_lo_q <= DEF_LO;
    end else if (we_i) begin
      if (wsel_i == SEL_E_LO) e_lo_q <= wdata_i;
      if (wsel_i == SEL_F_LO) f_lo_q <= wdata_i;
    end
  end

  generate
    if (OFF_W > LO_W) begin : g_hi
      logic [HI_W-1:0] e_hi_q, f_hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          e_hi_q <= '0;
          f_hi_q <= '0;
        end else if (we_i) begin
          if (wsel_i == SEL_E_HI) e_hi_q <= wdata_i[HI_W-1:0];
          if (wsel_i == SEL_F_HI) f_hi_q <= wdata_i[HI_W-1:0];
        end
      end
      assign n_o      = {e_hi_q, e_lo_q};
      assign m_o      = {f_hi_q, f_lo_q};
      assign e_hi_ext = LO_W'(e_hi_q);
      assign f_hi_ext = LO_W'(f_hi_q);
    end else begin : g_no_hi
      assign n_o      = e_lo_q[OFF_W-1:0];
      assign m_o      = f_lo_q[OFF_W-1:0];
      assign e_hi_ext = '0;
      assign f_hi_ext = '0;
    end
  endgenerate

  always_comb begin
    unique case (rsel_i)
      SEL_E_LO: rd_val_o = e_lo_q;
      SEL_E_HI: rd_val_o = e_hi_ext;
      SEL_F_LO: rd_val_o = f_lo_q;
      default:  rd_val_o = f_hi_ext;
    endcase
  end
endmodule

// File: rtl/flagoff_seq.sv
module flagoff_seq
  import flagoff_pkg::*;
#(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned OFF_W = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              wen1_ni,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              fifo_we_o,
  output logic              fifo_re_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              err_o,
  output logic [OFF_W-1:0]  n_o,
  output logic [OFF_W-1:0]  m_o
);
  logic w_prog, r_prog;
  logic rd_req, w_ld_phase, r_ld_phase;
  logic off_we, off_re, clash_w;
  logic [1:0] wptr, rptr;
  logic [LO_W-1:0] rd_val;
  logic err_q, vld_q;
  logic [DATA_W-1:0] rdata_q;
  logic unused_wdata;

  flagoff_mode u_wmode (.clk_i(wclk_i), .rst_ni(rst_ni), .ld_i(ld_i), .prog_o(w_prog));
  flagoff_mode u_rmode (.clk_i(rclk_i), .rst_ni(rst_ni), .ld_i(ld_i), .prog_o(r_prog));

  assign rd_req     = ~ren1_ni & ~ren2_ni;
  assign w_ld_phase = w_prog & ~ld_i;
  assign r_ld_phase = r_prog & ~ld_i;
  assign off_we     = w_ld_phase & ~wen1_ni & ~rd_req;
  assign off_re     = r_ld_phase & rd_req & wen1_ni;
  assign clash_w    = w_ld_phase & ~wen1_ni & rd_req;
  assign fifo_we_o  = ~wen1_ni & ld_i;
  assign fifo_re_o  = rd_req & ~r_ld_phase;

  flagoff_ptr u_wptr (.clk_i(wclk_i), .rst_ni(rst_ni), .adv_i(off_we), .ptr_o(wptr));
  flagoff_ptr u_rptr (.clk_i(rclk_i), .rst_ni(rst_ni), .adv_i(off_re), .ptr_o(rptr));

  flagoff_regs #(.OFF_W(OFF_W)) u_regs (
    .clk_i   (wclk_i),
    .rst_ni  (rst_ni),
    .we_i    (off_we),
    .wsel_i  (wptr),
    .wdata_i (wdata_i[LO_W-1:0]),
    .rsel_i  (rptr),
    .n_o     (n_o),
    .m_o     (m_o),
    .rd_val_o(rd_val)
  );

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= clash_w;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= off_re;
      if (off_re) rdata_q <= DATA_W'(rd_val);
    end
  end

  assign err_o       = err_q;
  assign rdata_o     = rdata_q;
  assign rdata_vld_o = vld_q;
endmodule

// File: rtl/flagoff_chk.sv
module flagoff_chk #(
  parameter int unsigned OFF_W = 11
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             ld_i,
  input logic             wen1_ni,
  input logic             ren1_ni,
  input logic             ren2_ni,
  input logic             w_prog,
  input logic             r_prog,
  input logic [1:0]       wptr,
  input logic [1:0]       rptr,
  input logic             fifo_we_o,
  input logic             fifo_re_o,
  input logic             rdata_vld_o,
  input logic             err_o,
  input logic [OFF_W-1:0] n_o,
  input logic [OFF_W-1:0] m_o
);
  AST_WIDE_MODE_KEEPS_OFFSETS: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !w_prog |=> ($stable(n_o) && $stable(m_o))); // R1

  AST_WIDE_MODE_NO_READBACK: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !r_prog |=> ($stable(rptr) && !rdata_vld_o)); // R1

  AST_WPTR_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_prog && !ld_i && !wen1_ni && (ren1_ni || ren2_ni)) |=> (wptr == 2'($past(wptr) + 2'd1))); // R2

  AST_WPTR_HOLD_OUTSIDE_LOAD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ld_i |=> $stable(wptr)); // R4

  AST_NO_FIFO_WRITE_IN_LOAD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_prog && !ld_i) |-> !fifo_we_o); // R5

  AST_READBACK_NEEDS_ENABLES: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rdata_vld_o |-> ($past(!ren1_ni) && $past(!ren2_ni) && $past(!ld_i))); // R6

  AST_CLASH_FLAGGED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_prog && !ld_i && !wen1_ni && !ren1_ni && !ren2_ni) |=> (err_o && $stable(n_o) && $stable(m_o) && $stable(wptr))); // R8

  AST_CLASH_NO_READ: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (r_prog && !ld_i && !wen1_ni && !ren1_ni && !ren2_ni) |=> (!rdata_vld_o && $stable(rptr))); // R8

  AST_FIFO_READ_EXCLUSIVE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    fifo_re_o |=> !rdata_vld_o); // R9
endmodule

bind flagoff_seq flagoff_chk #(.OFF_W(OFF_W)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .ld_i       (ld_i),
  .wen1_ni    (wen1_ni),
  .ren1_ni    (ren1_ni),
  .ren2_ni    (ren2_ni),
  .w_prog     (w_prog),
  .r_prog     (r_prog),
  .wptr       (wptr),
  .rptr       (rptr),
  .fifo_we_o  (fifo_we_o),
  .fifo_re_o  (fifo_re_o),
  .rdata_vld_o(rdata_vld_o),
  .err_o      (err_o),
  .n_o        (n_o),
  .m_o        (m_o)
);

// File: tb/tb_flagoff_seq.sv
module tb_flagoff_seq;
  localparam int unsigned DEPTH  = 2048;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned OFF_W  = 11;
  localparam int unsigned HI_MSK = (1 << (OFF_W - 8)) - 1;

  logic clk = 1'b0;
  logic rst_n, ld, wen1_n, ren1_n, ren2_n;
  logic [DATA_W-1:0] wdata;
  logic fifo_we, fifo_re, rvld, err;
  logic [DATA_W-1:0] rdata;
  logic [OFF_W-1:0] n, m;

  int total = 0;
  int bad = 0;
  int reg_m[4];
  int wp, rp;
  bit prog;

  always #5 clk = ~clk;

  flagoff_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .ld_i(ld),
    .wen1_ni(wen1_n), .ren1_ni(ren1_n), .ren2_ni(ren2_n), .wdata_i(wdata),
    .fifo_we_o(fifo_we), .fifo_re_o(fifo_re), .rdata_o(rdata),
    .rdata_vld_o(rvld), .err_o(err), .n_o(n), .m_o(m)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int mask_of(int idx);
    return (idx % 2 == 0) ? 255 : HI_MSK;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic step(string tag, bit l, bit w, bit r1, bit r2, int d);
    bit load, rdreq, offw, offr, clash;
    int exp_rd;
    ld = l; wen1_n = w; ren1_n = r1; ren2_n = r2; wdata = DATA_W'(d);
    load  = prog && !l;
    rdreq = !r1 && !r2;
    offw  = load && !w && !rdreq;
    offr  = load && rdreq && w;
    clash = load && !w && rdreq;
    exp_rd = 0;
    #1;
    chk(tag, "fifo_we_o (R5)", int'(fifo_we), int'(!w && l));
    chk(tag, "fifo_re_o (R9)", int'(fifo_re), int'(rdreq && !load));
    @(posedge clk);
    if (offr) begin
      exp_rd = reg_m[rp];
      rp = (rp + 1) % 4;
    end
    if (offw) begin
      reg_m[wp] = d & mask_of(wp);
      wp = (wp + 1) % 4;
    end
    #2;
    chk(tag, "n_o (R10)", int'(n), (reg_m[1] << 8) | reg_m[0]);
    chk(tag, "m_o (R10)", int'(m), (reg_m[3] << 8) | reg_m[2]);
    chk(tag, "err_o (R8)", int'(err), int'(clash));
    chk(tag, "rdata_vld_o (R6)", int'(rvld), int'(offr));
    if (offr) chk(tag, "rdata_o (R6)", int'(rdata), exp_rd);
    @(negedge clk);
  endtask

  task automatic do_reset(bit l);
    rst_n = 1'b0; ld = l; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_m[0] = 7; reg_m[1] = 0; reg_m[2] = 7; reg_m[3] = 0;
    wp = 0; rp = 0; prog = !l;
    chk("R3", "n_o after reset", int'(n), 7);
    chk("R3", "m_o after reset", int'(m), 7);
    chk("R3", "err_o after reset", int'(err), 0);
    chk("R3", "rdata_vld_o after reset", int'(rvld), 0);
    chk("R3", "rdata_o after reset", int'(rdata), 0);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R2: ordered writes, wrap on the fifth
    for (int i = 0; i < 6; i++) step("R2", 0, 0, 1, 1, (i * 53 + 17) % 512);
    // R6: read-back walks the same order and wraps
    for (int i = 0; i < 5; i++) step("R6", 0, 1, 0, 0, 0);
    // R7: all-ones data into every register
    for (int i = 0; i < 4; i++) step("R7", 0, 0, 1, 1, 511);
    for (int i = 0; i < 4; i++) step("R7", 0, 1, 0, 0, 0);
    // R4: sessions broken by ld high keep the pointers
    step("R4", 0, 0, 1, 1, 9'h0A5);
    step("R4", 1, 1, 1, 1, 0);
    step("R4", 0, 0, 1, 1, 9'h1C6);
    step("R4", 0, 1, 0, 0, 0);
    step("R4", 1, 1, 1, 1, 0);
    step("R4", 0, 1, 0, 0, 0);
    // R5: no-op and plain FIFO write
    step("R5", 0, 1, 1, 1, 9'h1FF);
    step("R5", 1, 0, 1, 1, 9'h055);
    // R9: plain FIFO read versus offset read
    step("R9", 1, 1, 0, 0, 0);
    step("R9", 0, 1, 0, 0, 0);
    // R8: simultaneous offset write and read refused
    step("R8", 0, 0, 0, 0, 9'h0EE);
    step("R8", 0, 0, 1, 1, 9'h012);
    step("R8", 0, 1, 0, 0, 0);
    // R2: sweep of every pin combination in load mode
    for (int c = 0; c < 64; c++)
      step("R2", c[0], c[1], c[2], c[3], (c * 29 + 3) % 512);
    // R1: wide mode
    do_reset(1'b1);
    step("R1", 0, 0, 1, 1, 9'h0AA);
    step("R1", 0, 1, 0, 0, 0);
    for (int c = 0; c < 32; c++)
      step("R1", c[0], c[1], c[2], c[3], (c * 41 + 9) % 512);
    // R3: pointers back at register 0 after a new reset
    do_reset(1'b0);
    step("R3", 0, 1, 0, 0, 0);
    step("R3", 0, 0, 1, 1, 9'h0AB);
    summary();
    $finish;
  end
endmodule